// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Cause

This peripheral holds two independent down-counters that step once per system clock, plus a small interrupt unit. Each counter has a live count and a reload value. Two control bits per counter set its behaviour. One bit enables counting. The other chooses between free-running periodic operation, where an expired counter reloads, and one-shot operation, where the counter stops at zero. Every expiry posts a sticky cause bit. A mask register gates the cause bits, and the gated bits are ORed into a single interrupt line.

Software reaches the block over a single-cycle register bus. Writes take effect at the clock edge that samples them, and reads are returned combinationally while the bus is selected. Because the live count falls over time, its bitwise inverse gives a rising timestamp. A system can therefore use one counter as a free-running time base and the other as a programmable event source.

Each counter runs a three-state machine:

| State | Meaning |
|---|---|
| IDLE | The enable bit is clear and the count is held. |
| RUN | The counter is counting. |
| SPENT | A one-shot interval has ended and the count sits at zero. |

The machine moves between these states as follows:

| From | To | Condition |
|---|---|---|
| any state | IDLE | The enable bit is clear. |
| IDLE | RUN | The enable bit is set. |
| RUN | RUN | The count is not zero, or it expires with reload on. |
| IDLE or RUN | SPENT | The counter expires with reload off. |
| SPENT | RUN | The live count is written while enabled. |
| any state | IDLE | The live count is written while disabled. |

An expiry happens in any counting cycle that begins with the count at zero.

Top module: `dual_dtimer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The control word sits at offset 0x000, and only its bits [3:0] read back; all other bits read zero. Its fields are:
  - bit 0 enables timer 0;
  - bit 1 selects reload for timer 0;
  - bit 2 enables timer 1;
  - bit 3 selects reload for timer 1.
- R3: While its enable bit is set, a counter decrements by one on each clock. Its value register (0x014 for timer 0, 0x01C for timer 1) returns the live count. While disabled, the count is held.
- R4: With reload selected, an expiring counter loads its reload register (0x010 for timer 0, 0x018 for timer 1) and keeps counting. With N in both the reload and value registers, expiries fall every N+1 clocks, the first one N+1 clocks after enabling.
- R5: With reload off, the counter sets its cause bit on the clock where it leaves zero, then holds at zero. It raises no further cause until its value register is written again.
- R6: A write to a value register sets the count to the written data on that edge and takes precedence over that edge's decrement. Writing a spent counter while it is enabled restarts it.
- R7: The cause register sits at 0x110 and the mask register at 0x114. In both, bit 1 belongs to timer 0 and bit 2 to timer 1. All other bits read zero, and writing ones to the cause register never sets a bit.
- R8: Writing the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. If an expiry lands on the same edge as a clear, the cause bit stays set.
- R9: `irq` is high exactly when some cause bit and its mask bit are both set. It follows register changes without an added cycle of delay.
- R10: Clearing an enable bit stops the counter and leaves any pending cause bit set.
- R11: The reload registers read back what was written to them and do not change the live count. Reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting tick |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high |
| irq | output | 1 | Masked, ORed interrupt request |

## Verification
Two functions can fall on the same edge: a counter expiry and a software clear of that counter's cause bit. To provoke this, timer 1 is run periodically with a reload of 1, so that it expires on every second edge. The clear is then issued on a bus write timed to land exactly on an expiry edge. The result is judged by reading the cause register on the next cycle, which must still show bit 2 set. A later clear, issued after the counter has been stopped, must empty the register. A second overlap places a value-register write on an edge where the counter would otherwise decrement; the count read back must equal the written data, not one less.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    // Per-counter machine states.
    typedef enum logic [1:0] {
        CNT_IDLE  = 2'd0,
        CNT_RUN   = 2'd1,
        CNT_SPENT = 2'd2
    } cnt_state_e;

    // Register offsets; timer i registers sit at base + TMR_STRIDE*i.
    localparam logic [11:0] OFS_CTRL  = 12'h000;
    localparam logic [11:0] OFS_RLD   = 12'h010;
    localparam logic [11:0] OFS_VAL   = 12'h014;
    localparam logic [11:0] OFS_CAUSE = 12'h110;
    localparam logic [11:0] OFS_MASK  = 12'h114;
    localparam int          TMR_STRIDE = 8;

    // Timer i owns cause/mask bit CAUSE_LSB + i.
    localparam int CAUSE_LSB = 1;

endpackage

// File: rtl/dtimer_counter.sv
module dtimer_counter
    import dtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rl,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             expire
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] rld_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            count_q <= '0;
            rld_q   <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (rld_wr) begin
                rld_q <= rld_val;
            end
        end
    end

    // Next state, next count and expiry strobe.
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        expire  = 1'b0;
        if (load) begin
            count_d = load_val;
            state_d = en ? CNT_RUN : CNT_IDLE;
        end else if (!en) begin
            state_d = CNT_IDLE;
        end else begin
            unique case (state_q)
                CNT_IDLE, CNT_RUN: begin
                    if (count_q != '0) begin
                        count_d = count_q - 1'b1;
                        state_d = CNT_RUN;
                    end else begin
                        expire = 1'b1;
                        if (rl) begin
                            count_d = rld_q;
                            state_d = CNT_RUN;
                        end else begin
                            state_d = CNT_SPENT;
                        end
                    end
                end
                CNT_SPENT: state_d = CNT_SPENT;
                default:   state_d = CNT_IDLE;
            endcase
        end
    end

    assign count  = count_q;
    assign reload = rld_q;

endmodule

// File: rtl/dtimer_cause.sv
module dtimer_cause #(
    parameter int NT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] ev,
    input  logic          clr_wr,
    input  logic [NT-1:0] clr_pat,
    input  logic          mask_wr,
    input  logic [NT-1:0] mask_val,
    output logic [NT-1:0] cause,
    output logic [NT-1:0] mask,
    output logic          irq
);

    logic [NT-1:0] cause_q, mask_q;
    logic [NT-1:0] drop;

    // Bits written as zero are dropped; a new expiry overrides the drop.
    assign drop = {NT{clr_wr}} & ~clr_pat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= ev | (cause_q & ~drop);
            if (mask_wr) begin
                mask_q <= mask_val;
            end
        end
    end

    assign cause = cause_q;
    assign mask  = mask_q;
    assign irq   = |(cause_q & mask_q);

endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
    import dtimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int NT     = 2;
    localparam int CTRL_W = 2 * NT;

    logic                       wr_en;
    logic [CTRL_W-1:0]          ctrl_q;
    logic [NT-1:0]              tmr_en, tmr_rl, tmr_load, tmr_rwr, tmr_ev;
    logic [NT-1:0][CNT_W-1:0]   tmr_cnt, tmr_rld;
    logic                       cause_wr, mask_wr;
    logic [NT-1:0]              cause_q, mask_q;

    assign wr_en    = bus_sel & bus_wr;
    assign cause_wr = wr_en && (bus_addr == ADDR_W'(OFS_CAUSE));
    assign mask_wr  = wr_en && (bus_addr == ADDR_W'(OFS_MASK));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && (bus_addr == ADDR_W'(OFS_CTRL))) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        assign tmr_en[i]   = ctrl_q[2*i];
        assign tmr_rl[i]   = ctrl_q[2*i+1];
        assign tmr_load[i] = wr_en &&
            (bus_addr == ADDR_W'(int'(OFS_VAL) + TMR_STRIDE * i));
        assign tmr_rwr[i]  = wr_en &&
            (bus_addr == ADDR_W'(int'(OFS_RLD) + TMR_STRIDE * i));

        dtimer_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (tmr_en[i]),
            .rl       (tmr_rl[i]),
            .load     (tmr_load[i]),
            .load_val (bus_wdata[CNT_W-1:0]),
            .rld_wr   (tmr_rwr[i]),
            .rld_val  (bus_wdata[CNT_W-1:0]),
            .count    (tmr_cnt[i]),
            .reload   (tmr_rld[i]),
            .expire   (tmr_ev[i])
        );
    end

    dtimer_cause #(.NT(NT)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (tmr_ev),
        .clr_wr   (cause_wr),
        .clr_pat  (bus_wdata[CAUSE_LSB +: NT]),
        .mask_wr  (mask_wr),
        .mask_val (bus_wdata[CAUSE_LSB +: NT]),
        .cause    (cause_q),
        .mask     (mask_q),
        .irq      (irq)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata[CTRL_W-1:0] = ctrl_q;
            if (bus_addr == ADDR_W'(OFS_CAUSE)) bus_rdata[CAUSE_LSB +: NT] = cause_q;
            if (bus_addr == ADDR_W'(OFS_MASK))  bus_rdata[CAUSE_LSB +: NT] = mask_q;
            for (int i = 0; i < NT; i++) begin
                if (bus_addr == ADDR_W'(int'(OFS_RLD) + TMR_STRIDE * i))
                    bus_rdata[CNT_W-1:0] = tmr_rld[i];
                if (bus_addr == ADDR_W'(int'(OFS_VAL) + TMR_STRIDE * i))
                    bus_rdata[CNT_W-1:0] = tmr_cnt[i];
            end
        end
    end

endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
    parameter int NT    = 2,
    parameter int CNT_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     irq,
    input logic                     cause_wr,
    input logic [NT-1:0]            cause_q,
    input logic [NT-1:0]            mask_q,
    input logic [NT-1:0]            tmr_en,
    input logic [NT-1:0]            tmr_rl,
    input logic [NT-1:0]            tmr_load,
    input logic [NT-1:0]            tmr_ev,
    input logic [NT-1:0][CNT_W-1:0] tmr_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R9
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

    // R9
    irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == '0) |-> !irq);

    for (genvar i = 0; i < NT; i++) begin : g_chk
        // R3
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_en[i] && !tmr_load[i] && tmr_cnt[i] != '0)
            |=> (tmr_cnt[i] + ONE == $past(tmr_cnt[i])));

        // R10
        count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!tmr_en[i] && !tmr_load[i]) |=> $stable(tmr_cnt[i]));

        // R5
        oneshot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_ev[i] && !tmr_rl[i]) |=> (tmr_cnt[i] == '0));

        // R8
        cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[i] && !cause_wr) |=> cause_q[i]);

        // R7
        cause_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cause_q[i]) |-> $past(tmr_ev[i]));
    end

endmodule

bind dual_dtimer dtimer_chk #(.NT(NT), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .cause_wr (cause_wr),
    .cause_q  (cause_q),
    .mask_q   (mask_q),
    .tmr_en   (tmr_en),
    .tmr_rl   (tmr_rl),
    .tmr_load (tmr_load),
    .tmr_ev   (tmr_ev),
    .tmr_cnt  (tmr_cnt)
);

// File: tb/dual_dtimer_tb.sv
module dual_dtimer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dual_dtimer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Each bus operation occupies exactly one clock edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic q);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata; q = irq;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d; logic q;
        rd(12'h000, d, q); check("R1 ctrl", d, 0); check("R1 irq", {31'd0, q}, 0);
        rd(12'h010, d, q); check("R1 reload0", d, 0);
        rd(12'h014, d, q); check("R1 value0", d, 0);
        rd(12'h018, d, q); check("R1 reload1", d, 0);
        rd(12'h01C, d, q); check("R1 value1", d, 0);
        rd(12'h110, d, q); check("R1 cause", d, 0);
        rd(12'h114, d, q); check("R1 mask", d, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d; logic q;
        wr(12'h000, 32'hFFFF_FFFA);
        rd(12'h000, d, q); check("R2 ctrl readback", d, 32'h0000_000A);
        wr(12'h000, 32'h0);
        wr(12'h010, 32'h0000_1234);
        rd(12'h010, d, q); check("R11 reload0 readback", d, 32'h0000_1234);
        rd(12'h014, d, q); check("R11 value0 untouched", d, 0);
        rd(12'h004, d, q); check("R11 unmapped 0x004", d, 0);
        rd(12'h200, d, q); check("R11 unmapped 0x200", d, 0);
    endtask

    task automatic t_count;
        logic [31:0] d; logic q;
        wr(12'h014, 32'd100);
        wr(12'h000, 32'h1);
        rd(12'h014, d, q); check("R3 count start", d, 32'd100);
        rd(12'h014, d, q); check("R3 count step", d, 32'd99);
        idle(3);
        rd(12'h014, d, q); check("R3 count after idle", d, 32'd95);
        wr(12'h014, 32'd500);
        rd(12'h014, d, q); check("R6 write beats decrement", d, 32'd500);
        wr(12'h000, 32'h0);
        rd(12'h014, d, q); check("R3 count at stop", d, 32'd498);
        idle(2);
        rd(12'h014, d, q); check("R10 count held", d, 32'd498);
    endtask

    task automatic t_periodic;
        logic [31:0] d; logic q;
        wr(12'h018, 32'd3);
        wr(12'h01C, 32'd3);
        wr(12'h114, 32'h4);
        wr(12'h000, 32'hC);
        idle(3);
        rd(12'h110, d, q); check("R4 no early expiry", d, 0); check("R9 irq low", {31'd0, q}, 0);
        rd(12'h110, d, q); check("R4 first expiry", d, 32'h4); check("R9 irq high", {31'd0, q}, 1);
        wr(12'h110, 32'h0);
        rd(12'h01C, d, q); check("R4 reloaded count", d, 32'd1);
        rd(12'h110, d, q); check("R8 cleared", d, 0);
        rd(12'h110, d, q); check("R4 second expiry", d, 32'h4);
        wr(12'h000, 32'h0);
        wr(12'h110, 32'h0);
        rd(12'h110, d, q); check("R8 clear after stop", d, 0);
    endtask

    task automatic t_oneshot;
        logic [31:0] d; logic q;
        wr(12'h014, 32'd2);
        wr(12'h000, 32'h1);
        idle(2);
        rd(12'h014, d, q); check("R5 reached zero", d, 0);
        rd(12'h110, d, q); check("R5 expiry cause", d, 32'h2); check("R9 masked irq", {31'd0, q}, 0);
        idle(4);
        rd(12'h110, d, q); check("R5 cause sticky", d, 32'h2);
        rd(12'h014, d, q); check("R5 holds zero", d, 0);
        wr(12'h110, 32'h0);
        rd(12'h110, d, q); check("R5 no retrigger", d, 0);
        idle(3);
        rd(12'h110, d, q); check("R5 still no retrigger", d, 0);
        wr(12'h114, 32'h6);
        wr(12'h014, 32'd1);
        rd(12'h014, d, q); check("R6 restart value", d, 32'd1);
        rd(12'h110, d, q); check("R6 restart no cause yet", d, 0);
        rd(12'h110, d, q); check("R6 restart expiry", d, 32'h2); check("R9 unmasked irq", {31'd0, q}, 1);
        wr(12'h114, 32'h4);
        rd(12'h110, d, q); check("R9 irq gated by mask", {31'd0, q}, 0);
        wr(12'h000, 32'h0);
        wr(12'h110, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] d; logic q;
        wr(12'h018, 32'd1);
        wr(12'h01C, 32'd1);
        wr(12'h000, 32'hC);
        idle(3);
        wr(12'h110, 32'h0);
        rd(12'h110, d, q); check("R8 expiry wins over clear", d, 32'h4);
        wr(12'h000, 32'h0);
        wr(12'h110, 32'h4);
        rd(12'h110, d, q); check("R10 cause kept after stop", d, 32'h4);
        rd(12'h01C, d, q); check("R10 count held after stop", d, 32'd1);
        wr(12'h110, 32'h0);
        rd(12'h110, d, q); check("R8 zero clears", d, 0);
    endtask

    task automatic t_reserved;
        logic [31:0] d; logic q;
        wr(12'h110, 32'hFFFF_FFFF);
        rd(12'h110, d, q); check("R7 ones never set cause", d, 0);
        wr(12'h114, 32'hFFFF_FFFF);
        rd(12'h114, d, q); check("R7 mask bits", d, 32'h6); check("R9 no cause no irq", {31'd0, q}, 0);
        wr(12'h114, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_count();
        t_periodic();
        t_oneshot();
        t_race();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule